// File: doc/BRIEF.md
# Transfer Unit Packer with Fill Stuffing

This block sits on one lane of a display link transmitter, between the logic that steers pixel bytes onto lanes and the symbol encoder. It places the lane's data symbols into fixed frames of 64 symbol slots. Each frame holds a set number of data symbols at its front. The rest of the frame is stuffing, and control codes mark where the stuffing starts and ends. How many data symbols go into a frame follows the ratio of the stream rate to the link rate. That ratio is supplied as an unsigned fixed-point value with 6 integer bits and 10 fraction bits. A fraction accumulator spreads the fractional part over the frames, so that over many frames the average data count matches the ratio.

The input is a symbol stream with valid/ready and an end-of-line marker on the last symbol of each active line. The output carries one symbol per slot, with a flag that marks control codes and a valid flag. When a data slot comes due and no input symbol is present, the packer stalls. It never closes a frame early for lack of data. The one exception is the end of a line: the frame in progress is then abandoned, a blank-start code is emitted, and the next line begins a fresh frame.

Top module: `tu_packer`

## Requirements
- R1: Every frame not cut short by end of line spans exactly 64 valid output slots. The fill-end code, when present, sits in slot 63.
- R2: The data count of a frame is ratio[15:10] plus a carry. The carry is the overflow out of a 10-bit fraction accumulator that adds ratio[9:0] once per frame. Reset clears the accumulator, and so does each blank-start emission. Data slots occupy the front of the frame.
- R3: When the stuffing length is 2 or more, the first stuffing slot is the fill-start code (out_ctrl=1, out_sym=8'hFE) and the last is the fill-end code (out_ctrl=1, out_sym=8'hF7). Every slot between them is a data symbol 8'h00 with out_ctrl=0.
- R4: When the stuffing length is 1, that slot carries only the fill-end code. When it is 0, no fill code appears.
- R5: In a data slot with in_valid low, out_valid is low and the frame position holds. This is also the state after reset when the ratio is nonzero and no input is offered.
- R6: An accepted input symbol appears on out_sym in the same cycle, with out_ctrl=0.
- R7: After the symbol flagged in_eol is accepted, the next output slot is the blank-start code (out_ctrl=1, out_sym=8'hBC). The rest of that frame is dropped, and the next symbol starts slot 0 of a new frame.
- R8: in_ready is low in stuffing slots and blank-start slots. An input offered there is not consumed and appears later in a data slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio | input | 16 | Data-per-frame ratio, 6.10 unsigned fixed point |
| in_sym | input | 8 | Incoming data symbol |
| in_valid | input | 1 | in_sym is present |
| in_eol | input | 1 | in_sym is the last symbol of the active line |
| in_ready | output | 1 | Current slot takes a data symbol |
| out_sym | output | 8 | Output symbol or control code |
| out_ctrl | output | 1 | out_sym is a control code |
| out_valid | output | 1 | A slot is emitted this cycle |

## Verification
An error in the slot counter or in the latched data count moves the fill codes. At the frame boundary after the fault, the fill-end shows up in a slot other than 63, or the stuffing length no longer matches the expected ratio. A fraction accumulator that slips, or that is not cleared at end of line, first shows as a carry in the wrong frame. That is one data symbol too many or too few, at most one frame after the fault, and it shifts every later symbol of the line. A stuck end-of-line pending state shows at once, as a missing blank-start or one too many.

// File: rtl/tu_packer.sv
module tu_packer #(
  parameter int SYM_W  = 8,
  parameter int INT_W  = 6,
  parameter int FRAC_W = 10,
  parameter logic [SYM_W-1:0] K_FS = 8'hFE,
  parameter logic [SYM_W-1:0] K_FE = 8'hF7,
  parameter logic [SYM_W-1:0] K_BS = 8'hBC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [INT_W+FRAC_W-1:0] ratio,
  input  logic [SYM_W-1:0]        in_sym,
  input  logic                    in_valid,
  input  logic                    in_eol,
  output logic                    in_ready,
  output logic [SYM_W-1:0]        out_sym,
  output logic                    out_ctrl,
  output logic                    out_valid
);
  localparam int RW = INT_W + FRAC_W;

  logic [INT_W-1:0]  pos;
  logic [INT_W:0]    nval;
  logic [FRAC_W-1:0] frac;
  logic              load;
  logic              bs_pend;

  logic [FRAC_W:0] fsum;
  logic [INT_W:0]  n_new, n_cur, pos_x;
  logic            in_data, last, is_fs, step;

  assign fsum    = {1'b0, frac} + {1'b0, ratio[FRAC_W-1:0]};
  assign n_new   = {1'b0, ratio[RW-1:FRAC_W]} + {{INT_W{1'b0}}, fsum[FRAC_W]};
  assign n_cur   = load ? n_new : nval;
  assign pos_x   = {1'b0, pos};
  assign in_data = pos_x < n_cur;
  assign last    = &pos;
  assign is_fs   = (pos_x == n_cur) && !last;
  assign step    = !bs_pend && (!in_data || in_valid);

  assign in_ready  = !bs_pend && in_data;
  assign out_valid = bs_pend || !in_data || in_valid;
  assign out_ctrl  = bs_pend || (!in_data && (is_fs || last));

  always_comb begin
    if (bs_pend)      out_sym = K_BS;
    else if (in_data) out_sym = in_sym;
    else if (last)    out_sym = K_FE;
    else if (is_fs)   out_sym = K_FS;
    else              out_sym = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      nval    <= '0;
      frac    <= '0;
      load    <= 1'b1;
      bs_pend <= 1'b0;
    end else if (bs_pend) begin
      bs_pend <= 1'b0;
      frac    <= '0;
    end else if (step) begin
      if (load) begin
        nval <= n_new;
        frac <= fsum[FRAC_W-1:0];
        load <= 1'b0;
      end
      if (in_data && in_eol) begin
        pos     <= '0;
        load    <= 1'b1;
        bs_pend <= 1'b1;
      end else if (last) begin
        pos  <= '0;
        load <= 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tu_packer_chk.sv
module tu_packer_chk #(
  parameter int SYM_W = 8,
  parameter int INT_W = 6,
  parameter logic [SYM_W-1:0] K_FS = 8'hFE,
  parameter logic [SYM_W-1:0] K_FE = 8'hF7,
  parameter logic [SYM_W-1:0] K_BS = 8'hBC
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SYM_W-1:0] in_sym,
  input logic             in_valid,
  input logic             in_eol,
  input logic             in_ready,
  input logic [SYM_W-1:0] out_sym,
  input logic             out_ctrl,
  input logic             out_valid
);
  logic [INT_W-1:0] slot_cnt;
  logic is_bs, is_fs, is_fe, take;

  assign is_bs = out_valid && out_ctrl && out_sym == K_BS;
  assign is_fs = out_valid && out_ctrl && out_sym == K_FS;
  assign is_fe = out_valid && out_ctrl && out_sym == K_FE;
  assign take  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         slot_cnt <= '0;
    else if (is_bs)     slot_cnt <= '0;
    else if (out_valid) slot_cnt <= slot_cnt + 1'b1;
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> out_valid && !out_ctrl && out_sym == in_sym); // R6
  AST_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |-> !out_valid); // R5
  AST_BS_AFTER_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_eol |=> is_bs); // R7
  AST_CTRL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ctrl |-> !in_ready); // R8
  AST_FS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    is_fs |=> out_valid && ((!out_ctrl && out_sym == '0) || (out_ctrl && out_sym == K_FE))); // R3
  AST_FE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    is_fe |-> &slot_cnt); // R1
endmodule

bind tu_packer tu_packer_chk #(.SYM_W(SYM_W), .INT_W(INT_W), .K_FS(K_FS), .K_FE(K_FE), .K_BS(K_BS)) chk_i (.*);

// File: tb/tu_packer_tb_top.sv
module tu_packer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ratio = '0;
  logic [7:0]  in_sym = '0;
  logic        in_valid = 1'b0;
  logic        in_eol = 1'b0;
  logic        in_ready, out_ctrl, out_valid;
  logic [7:0]  out_sym;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tu_packer dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_line(input int ii, input int ff, input int len, input bit gaps, input int seed);
    int ek[1024];
    int es[1024];
    int en = 0, k = 0, frac = 0, sum, n, idx = 0, got = 0, cyc = 0;
    bit fin = 0;
    string tag;
    while (!fin) begin
      sum = frac + ff;
      n = ii + (sum >> 10);
      frac = sum & 1023;
      for (int p = 0; p < 64 && !fin; p++) begin
        if (p < n) begin
          ek[en] = 0; es[en] = (k * 7 + seed) & 255; en++; k++;
          if (k == len) begin ek[en] = 4; es[en] = 8'hBC; en++; fin = 1; end
        end else if (p == 63) begin
          ek[en] = (n == 63) ? 5 : 3; es[en] = 8'hF7; en++;
        end else if (p == n) begin
          ek[en] = 1; es[en] = 8'hFE; en++;
        end else begin
          ek[en] = 2; es[en] = 0; en++;
        end
      end
    end
    ratio = {ii[5:0], ff[9:0]};
    while (got < en && cyc < 5000) begin
      @(negedge clk);
      in_valid = (idx < len) && !(gaps && (cyc % 3 == 1));
      in_sym   = 8'((idx * 7 + seed) & 255);
      in_eol   = (idx == len - 1);
      #1;
      if (in_ready && !in_valid) chk(!out_valid, "R5", "out_valid during stall", out_valid, 0);
      if (out_valid) begin
        case (ek[got])
          0: tag = "R2/R6";
          1, 2: tag = "R3";
          3: tag = "R1/R3";
          4: tag = "R7";
          default: tag = "R4";
        endcase
        chk(out_ctrl == (ek[got] != 0 && ek[got] != 2), tag, "out_ctrl", out_ctrl, int'(ek[got] != 0 && ek[got] != 2));
        chk(out_sym == es[got][7:0], tag, "out_sym", out_sym, es[got]);
        if (ek[got] != 0) chk(!in_ready, "R8", "in_ready outside data slot", in_ready, 0);
        got++;
      end
      if (in_valid && in_ready) idx++;
      cyc++;
    end
    chk(got == en, "R1", "output slot count", got, en);
    chk(idx == len, "R8", "symbols consumed", idx, len);
    @(negedge clk);
    in_valid = 0;
    in_eol = 0;
  endtask

  task automatic t_reset;
    ratio = {6'd40, 10'd0};
    in_valid = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(!out_valid, "R5", "reset out_valid", out_valid, 0);
    chk(in_ready, "R5", "reset in_ready", in_ready, 1);
  endtask

  initial begin
    t_reset();
    run_line(40, 0, 100, 0, 3);
    run_line(50, 384, 160, 1, 11);
    run_line(50, 384, 160, 0, 17);
    run_line(63, 0, 130, 1, 5);
    run_line(63, 1023, 200, 0, 29);
    run_line(20, 0, 20, 0, 41);
    run_line(20, 0, 1, 1, 43);
    run_line(1, 1000, 5, 0, 47);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule